// File: doc/BRIEF.md
# Reference Clock Failover Monitor

This block watches two reference clocks, ref0 (the primary, always present) and ref1 (the backup), from a separate free-running monitor clock. Each reference is brought into the monitor domain through a chain of flip-flops. The block then counts how many monitor cycles have passed since that reference last changed level. If a reference stays quiet for too long, its loss flag is raised. The flag drops again as soon as a fresh edge is seen.

The block keeps one selection register that says which reference is in use. It drives two outputs from it: a one-bit active indicator and a one-hot select for an external clock multiplexer. The switching of the clocks themselves happens outside this block.

The selection changes in two ways:
- **Automatic failover:** when the reference in use is flagged lost and the other one is healthy.
- **Manual switch:** each rising edge of a request from core logic flips the choice, even onto a flagged input.

Top module: `refclk_failover`

## Requirements
- R1: After reset, `active` is 0, `ref_bad` is 2'b00 and `mux_sel` is 2'b01.
- R2: `active` is 0 while ref0 is selected and 1 while ref1 is selected. `mux_sel` is always one-hot: bit 0 high selects ref0, and bit 1 high selects ref1.
- R3: A reference whose level changes at least once every TIMEOUT monitor cycles never has its `ref_bad` bit set. Bit 0 of `ref_bad` belongs to ref0 and bit 1 belongs to ref1.
- R4: A rising edge on `swap_req` flips the selection at the next monitor clock edge. Holding `swap_req` high after that causes no further flips.
- R5: When the selected reference is flagged and the other reference is not, the selection moves to the other reference at the next monitor clock edge.
- R6: A flagged reference is cleared once an edge of it is seen again. Its recovery alone does not move the selection back to it.
- R7: A synchronous reset in the middle of operation returns the selection to ref0, clears both flags and restarts the silence counters. A reference stalled across the reset is not flagged within the first TIMEOUT/2 cycles after reset.
- R8: While both references are flagged, the selection holds its value.
- R9: A manual switch is taken even when it lands on a flagged reference. Automatic failover then moves the selection back one clock later if the other reference is healthy.
- R10: When a manual switch and an automatic failover fall on the same clock edge, the selection flips exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| ref0 | input | 1 | Primary reference clock, sampled as data |
| ref1 | input | 1 | Backup reference clock, sampled as data |
| swap_req | input | 1 | Manual switch request; its rising edge flips the selection |
| active | output | 1 | 0 when ref0 is selected, 1 when ref1 is selected |
| ref_bad | output | 2 | Per-reference loss flags; bit 0 is ref0, bit 1 is ref1 |
| mux_sel | output | 2 | One-hot select for an external clock multiplexer |

## Verification
A manual switch and an automatic failover can both want to flip the selection on the same monitor edge. A design that handles them separately would flip twice and end up where it started.

The bench provokes this case as follows:
1. It stalls both references, then restarts only ref1 while ref0 is selected.
2. At the falling clock edge where the ref1 flag is first seen cleared, it raises `swap_req`. Failover and the manual request therefore land on the same rising edge.
3. It expects ref1 to be selected one cycle later.

A second case issues a manual switch onto a flagged reference and checks, cycle by cycle, that failover returns the selection one clock later.

// File: rtl/refmon_pkg.sv
`timescale 1ns/1ps
package refmon_pkg;
  typedef enum logic {
    PICK_REF0 = 1'b0,
    PICK_REF1 = 1'b1
  } ref_pick_e;

  localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/refmon_sync.sv
`timescale 1ns/1ps
module refmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refmon_watch.sv
`timescale 1ns/1ps
module refmon_watch #(
  parameter int unsigned TIMEOUT     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic bad_o
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             level_s;
  logic             level_d;
  logic             edge_seen;
  logic [CNT_W-1:0] quiet_cnt;
  logic             bad_q;

  refmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ref_in),
    .q   (level_s)
  );

  assign edge_seen = level_s ^ level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d   <= 1'b0;
      quiet_cnt <= '0;
      bad_q     <= 1'b0;
    end else begin
      level_d <= level_s;
      if (edge_seen) begin
        quiet_cnt <= '0;
        bad_q     <= 1'b0;
      end else begin
        if (quiet_cnt != LAST) quiet_cnt <= quiet_cnt + 1'b1;
        if (quiet_cnt == LAST) bad_q <= 1'b1;
      end
    end
  end

  assign bad_o = bad_q;

  // R6: a seen edge leaves the flag clear on the following cycle
  p_clear_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !bad_o);
endmodule

// File: rtl/refmon_select.sv
`timescale 1ns/1ps
module refmon_select
  import refmon_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] bad_i,
  input  logic                swap_req,
  output ref_pick_e           sel_o
);
  ref_pick_e sel_q;
  logic      req_q;
  logic      swap_pulse;
  logic      cur_idx;
  logic      auto_go;

  assign swap_pulse = swap_req & ~req_q;
  assign cur_idx    = sel_q;
  assign auto_go    = bad_i[cur_idx] & ~bad_i[~cur_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= PICK_REF0;
      req_q <= 1'b0;
    end else begin
      req_q <= swap_req;
      if (swap_pulse || auto_go) sel_q <= ref_pick_e'(~sel_q);
    end
  end

  assign sel_o = sel_q;

  // R5: failover leaves a lost reference for a healthy one
  p_auto_leave_r5: assert property (@(posedge clk) disable iff (rst)
    (bad_i[sel_o] && !bad_i[~sel_o] && !swap_pulse) |=> (sel_o != $past(sel_o)));

  // R8: with both references lost and no request, the choice holds
  p_hold_both_bad_r8: assert property (@(posedge clk) disable iff (rst)
    (bad_i == 2'b11 && !swap_pulse) |=> $stable(sel_o));

  // R10: a manual request flips exactly once, whatever failover wants
  p_single_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    swap_pulse |=> (sel_o != $past(sel_o)));
endmodule

// File: rtl/refclk_failover.sv
`timescale 1ns/1ps
module refclk_failover
  import refmon_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref0,
  input  logic       ref1,
  input  logic       swap_req,
  output logic       active,
  output logic [1:0] ref_bad,
  output logic [1:0] mux_sel
);
  logic [NUM_REFS-1:0] refs;
  logic [NUM_REFS-1:0] bad_w;
  ref_pick_e           sel_w;

  assign refs = {ref1, ref0};

  generate
    for (genvar i = 0; i < NUM_REFS; i++) begin : g_watch
      refmon_watch #(
        .TIMEOUT     (TIMEOUT),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_watch (
        .clk    (clk),
        .rst    (rst),
        .ref_in (refs[i]),
        .bad_o  (bad_w[i])
      );
    end
  endgenerate

  refmon_select u_select (
    .clk      (clk),
    .rst      (rst),
    .bad_i    (bad_w),
    .swap_req (swap_req),
    .sel_o    (sel_w)
  );

  assign active  = sel_w;
  assign ref_bad = bad_w;
  assign mux_sel = {sel_w == PICK_REF1, sel_w == PICK_REF0};

  // R2: exactly one multiplexer leg is selected, and it matches the indicator
  p_mux_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(mux_sel) == 1) && (mux_sel[1] == active));
endmodule

// File: tb/refclk_failover_test.sv
`timescale 1ns/1ps
module refclk_failover_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO         = 16;

  typedef struct {
    string      tag;
    logic       act;
    logic [1:0] bad;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref0 = 1'b0;
  logic       ref1 = 1'b0;
  logic       run0 = 1'b1;
  logic       run1 = 1'b1;
  logic       swap_req = 1'b0;
  logic       active;
  logic [1:0] ref_bad;
  logic [1:0] mux_sel;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  refclk_failover #(.TIMEOUT(TO), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .rst      (rst),
    .ref0     (ref0),
    .ref1     (ref1),
    .swap_req (swap_req),
    .active   (active),
    .ref_bad  (ref_bad),
    .mux_sel  (mux_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always begin
    #17;
    if (run0) ref0 <= ~ref0;
  end

  always begin
    #23;
    if (run1) ref1 <= ~ref1;
  end

  // monitor: pops expected items and compares them at falling edges
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (active !== e.act || ref_bad !== e.bad || mux_sel !== {e.act, ~e.act}) begin
          n_fails++;
          $display("FAIL %s: active=%b ref_bad=%b mux_sel=%b, expected active=%b ref_bad=%b mux_sel=%b",
                   e.tag, active, ref_bad, mux_sel, e.act, e.bad, {e.act, ~e.act});
        end
      end
    end
  end

  // driver side: push an expectation that is judged at the next falling edge
  task automatic expect_state(input string tag, input logic act, input logic [1:0] bad);
    exp_t e;
    #1;
    e.tag = tag;
    e.act = act;
    e.bad = bad;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    expect_state("R1 reset state", 1'b0, 2'b00);

    idle(40);
    expect_state("R3 both toggling", 1'b0, 2'b00);

    @(negedge clk); swap_req = 1'b1;
    idle(5);
    expect_state("R4 held request flips once", 1'b1, 2'b00);
    swap_req = 1'b0;
    idle(3);
    swap_req = 1'b1;
    idle(2);
    swap_req = 1'b0;
    expect_state("R4/R2 second request back to ref0", 1'b0, 2'b00);

    run0 = 1'b0;
    idle(TO + 10);
    expect_state("R5 failover to ref1", 1'b1, 2'b01);

    run0 = 1'b1;
    idle(10);
    expect_state("R6 flag clears, no return", 1'b1, 2'b00);

    run1 = 1'b0;
    idle(TO + 10);
    expect_state("R5 failover to ref0", 1'b0, 2'b10);

    run0 = 1'b0;
    idle(TO + 10);
    expect_state("R8 both lost, hold", 1'b0, 2'b11);

    // R10: raise the request in the cycle where failover is already due
    run1 = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ref_bad[1] == 1'b0) break;
    end
    swap_req = 1'b1;
    expect_state("R10 coincident flip once", 1'b1, 2'b01);
    swap_req = 1'b0;
    idle(2);

    // R9: manual switch onto lost ref0, failover returns next clock
    @(negedge clk);
    swap_req = 1'b1;
    expect_state("R9 manual onto lost input", 1'b0, 2'b01);
    swap_req = 1'b0;
    expect_state("R9 failover returns", 1'b1, 2'b01);

    idle(2);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    expect_state("R7 mid-run reset", 1'b0, 2'b00);
    idle(TO/2 - 2);
    expect_state("R7 counters restarted", 1'b0, 2'b00);
    idle(TO + 10);
    expect_state("R7/R5 stalled ref0 flagged later", 1'b1, 2'b01);

    run0 = 1'b1;
    idle(40);
    expect_state("R3 ref0 recovered", 1'b1, 2'b00);

    idle(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule